// File: doc/BRIEF.md
# Maskable Interrupt Entry Unit

This block takes one external interrupt line into a processor core. When a request is present and the interrupt-enable bit of the current status word is set, it accepts the request in that same cycle. Accepting means three things. The core is told to redirect fetch to a fixed vector. The current program counter and status word are copied into backup registers. The live status word is cleared to zero. If the outgoing status word had the stack-mode bit set, a stack-pointer bank swap strobe is also raised, and the bank select follows the new (zero) stack-mode value.

When a request arrives while interrupts are masked, the block keeps it as a single pending request and tries it again on every later cycle until it is accepted. Only one request can be held. Requests that arrive while one is already pending are lost. A debug trap raised in the same cycle takes precedence over the interrupt, and the request waits as pending.

All outputs are combinational functions of the current inputs and one pending flag. The core samples the load strobes at its next clock edge.

Top module: `irq_entry_unit`

## Requirements
- R1: After reset no request is pending, so with `irq_pulse` low no strobe is raised even when interrupts are enabled.
- R2: A request (new pulse or pending) while the enable bit `stat_now[26]` is 1 and `dbg_trap` is 0 raises `redir_vld` in the same cycle, with `redir_pc` equal to the vector 0xFFFFF138.
- R3: In the accepting cycle `bkpc_we` and `bkstat_we` are raised, with `bkpc_d` equal to `pc_now` and `bkstat_d` equal to `stat_now`.
- R4: In the accepting cycle `stat_we` is raised with `stat_d` all zero.
- R5: In the accepting cycle `sp_swap` is 1 exactly when the stack-mode bit `stat_now[31]` is 1, and `sp_sel` is 0.
- R6: A request seen with the enable bit at 0 raises nothing in that cycle. It is retried every cycle and is accepted in the first later cycle in which the enable bit is 1, without a new pulse.
- R7: A pulse arriving while a request is already pending is discarded, so it gives no second acceptance.
- R8: Acceptance clears the pending request, including a pulse that arrives in the accepting cycle. The next cycle raises nothing unless a new pulse arrives.
- R9: With `dbg_trap` at 1 no acceptance happens. A request present in that cycle stays pending and is accepted later.
- R10: In any cycle without an acceptance, all of `redir_vld`, `bkpc_we`, `bkstat_we`, `stat_we` and `sp_swap` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_pulse | input | 1 | External interrupt request, one cycle |
| dbg_trap | input | 1 | Debug trap taken this cycle; has priority |
| pc_now | input | PC_W | Current program counter |
| stat_now | input | SW_W | Current status word |
| redir_vld | output | 1 | Fetch redirect strobe |
| redir_pc | output | PC_W | Redirect target (interrupt vector) |
| bkpc_we | output | 1 | Backup PC load strobe |
| bkpc_d | output | PC_W | Value for backup PC |
| bkstat_we | output | 1 | Backup status load strobe |
| bkstat_d | output | SW_W | Value for backup status |
| stat_we | output | 1 | Status word load strobe |
| stat_d | output | SW_W | New status word (zero) |
| sp_swap | output | 1 | Stack-pointer bank swap strobe |
| sp_sel | output | 1 | Stack bank selected after the swap |

## Verification
Two events can fall in the same cycle: a debug trap and an interrupt request. A third case is a fresh pulse landing in the cycle where a pending request is finally accepted. The bench drives the trap and the pulse together with interrupts enabled and expects no strobe. It then expects the acceptance in the next cycle with no new pulse. For the second case it drives a pulse in the same cycle that enabling lets the pending request through, and expects one acceptance followed by a quiet cycle.

// File: rtl/irqe_pkg.sv
package irqe_pkg;

   // Map a bit number to a vector index, counting from either end.
   function automatic int unsigned bit_index(int unsigned pos, int unsigned width, bit msb_first);
      return msb_first ? (width - 1 - pos) : pos;
   endfunction

   typedef struct packed {
      logic take;
      logic swap;
   } accept_t;

endpackage

// File: rtl/irqe_pend.sv
module irqe_pend (
   input  logic clk,
   input  logic rst_n,
   input  logic req_new,
   input  logic take,
   output logic pend_q
);
   // One-deep holder: acceptance clears, a new request sets, otherwise hold.
   // A request arriving while already set leaves the flag unchanged (dropped).
   always_ff @(posedge clk) begin
      if (!rst_n)       pend_q <= 1'b0;
      else if (take)    pend_q <= 1'b0;
      else if (req_new) pend_q <= 1'b1;
   end
endmodule

// File: rtl/irqe_gate.sv
module irqe_gate
   import irqe_pkg::*;
(
   input  logic    req_new,
   input  logic    pend_q,
   input  logic    ie_bit,
   input  logic    sm_bit,
   input  logic    dbg_trap,
   output accept_t acc
);
   logic req_any;
   always_comb begin
      req_any  = req_new | pend_q;
      acc.take = req_any & ie_bit & ~dbg_trap;
      acc.swap = acc.take & sm_bit;
   end
endmodule

// File: rtl/irqe_save.sv
module irqe_save
   import irqe_pkg::*;
#(
   parameter int unsigned PC_W   = 32,
   parameter int unsigned SW_W   = 32,
   parameter logic [PC_W-1:0] VECTOR = 32'hFFFF_F138
) (
   input  accept_t         acc,
   input  logic [PC_W-1:0] pc_now,
   input  logic [SW_W-1:0] stat_now,
   output logic            redir_vld,
   output logic [PC_W-1:0] redir_pc,
   output logic            bkpc_we,
   output logic [PC_W-1:0] bkpc_d,
   output logic            bkstat_we,
   output logic [SW_W-1:0] bkstat_d,
   output logic            stat_we,
   output logic [SW_W-1:0] stat_d,
   output logic            sp_swap,
   output logic            sp_sel
);
   always_comb begin
      redir_vld = acc.take;
      redir_pc  = VECTOR;
      bkpc_we   = acc.take;
      bkpc_d    = pc_now;
      bkstat_we = acc.take;
      bkstat_d  = stat_now;
      stat_we   = acc.take;
      stat_d    = '0;
      sp_swap   = acc.swap;
      sp_sel    = 1'b0;
   end
endmodule

// File: rtl/irq_entry_unit.sv
module irq_entry_unit
   import irqe_pkg::*;
#(
   parameter int unsigned PC_W      = 32,
   parameter int unsigned SW_W      = 32,
   parameter int unsigned IE_POS    = 5,
   parameter int unsigned SM_POS    = 0,
   parameter bit          MSB_FIRST = 1'b1,
   parameter logic [PC_W-1:0] VECTOR = 32'hFFFF_F138
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            irq_pulse,
   input  logic            dbg_trap,
   input  logic [PC_W-1:0] pc_now,
   input  logic [SW_W-1:0] stat_now,
   output logic            redir_vld,
   output logic [PC_W-1:0] redir_pc,
   output logic            bkpc_we,
   output logic [PC_W-1:0] bkpc_d,
   output logic            bkstat_we,
   output logic [SW_W-1:0] bkstat_d,
   output logic            stat_we,
   output logic [SW_W-1:0] stat_d,
   output logic            sp_swap,
   output logic            sp_sel
);
   localparam int unsigned IE_IDX = bit_index(IE_POS, SW_W, MSB_FIRST);
   localparam int unsigned SM_IDX = bit_index(SM_POS, SW_W, MSB_FIRST);

   generate
      if (IE_POS >= SW_W || SM_POS >= SW_W) begin : g_bad_pos
         $error("status bit position outside status word");
      end
      if (IE_POS == SM_POS) begin : g_same_pos
         $error("enable and stack-mode bits must differ");
      end
      if (PC_W < 2) begin : g_bad_pcw
         $error("PC width too small");
      end
   endgenerate

   logic    ie_bit, sm_bit, pend_q;
   accept_t acc;

   generate
      if (MSB_FIRST) begin : g_msb
         assign ie_bit = stat_now[IE_IDX];
         assign sm_bit = stat_now[SM_IDX];
      end else begin : g_lsb
         assign ie_bit = stat_now[IE_POS];
         assign sm_bit = stat_now[SM_POS];
      end
   endgenerate

   irqe_pend u_pend (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_new (irq_pulse),
      .take    (acc.take),
      .pend_q  (pend_q)
   );

   irqe_gate u_gate (
      .req_new  (irq_pulse),
      .pend_q   (pend_q),
      .ie_bit   (ie_bit),
      .sm_bit   (sm_bit),
      .dbg_trap (dbg_trap),
      .acc      (acc)
   );

   irqe_save #(.PC_W(PC_W), .SW_W(SW_W), .VECTOR(VECTOR)) u_save (
      .acc       (acc),
      .pc_now    (pc_now),
      .stat_now  (stat_now),
      .redir_vld (redir_vld),
      .redir_pc  (redir_pc),
      .bkpc_we   (bkpc_we),
      .bkpc_d    (bkpc_d),
      .bkstat_we (bkstat_we),
      .bkstat_d  (bkstat_d),
      .stat_we   (stat_we),
      .stat_d    (stat_d),
      .sp_swap   (sp_swap),
      .sp_sel    (sp_sel)
   );
endmodule

// File: rtl/irq_entry_unit_chk.sv
module irq_entry_unit_chk
   import irqe_pkg::*;
#(
   parameter int unsigned PC_W      = 32,
   parameter int unsigned SW_W      = 32,
   parameter int unsigned IE_POS    = 5,
   parameter int unsigned SM_POS    = 0,
   parameter bit          MSB_FIRST = 1'b1,
   parameter logic [PC_W-1:0] VECTOR = 32'hFFFF_F138
) (
   input logic            clk,
   input logic            rst_n,
   input logic            irq_pulse,
   input logic            dbg_trap,
   input logic [PC_W-1:0] pc_now,
   input logic [SW_W-1:0] stat_now,
   input logic            redir_vld,
   input logic [PC_W-1:0] redir_pc,
   input logic            bkpc_we,
   input logic [PC_W-1:0] bkpc_d,
   input logic            bkstat_we,
   input logic [SW_W-1:0] bkstat_d,
   input logic            stat_we,
   input logic [SW_W-1:0] stat_d,
   input logic            sp_swap,
   input logic            sp_sel
);
   localparam int unsigned IE_C = bit_index(IE_POS, SW_W, MSB_FIRST);
   localparam int unsigned SM_C = bit_index(SM_POS, SW_W, MSB_FIRST);

   logic live_q;
   always_ff @(posedge clk) begin
      if (!rst_n) live_q <= 1'b0;
      else        live_q <= 1'b1;
   end

   AST_VECTOR_ON_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      redir_vld |-> redir_pc == VECTOR); // R2
   AST_TAKE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      redir_vld |-> (stat_now[IE_C] && !dbg_trap)); // R9
   AST_BACKUP_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
      bkstat_we |-> (bkstat_d == stat_now && bkpc_d == pc_now)); // R3
   AST_STATUS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      stat_we |-> stat_d == '0); // R4
   AST_SWAP_FOLLOWS_SM: assert property (@(posedge clk) disable iff (!rst_n)
      sp_swap |-> (redir_vld && stat_now[SM_C] && !sp_sel)); // R5
   AST_RETRY_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      (live_q && stat_now[IE_C] && !dbg_trap && $past(irq_pulse && !redir_vld))
      |-> redir_vld); // R6
   AST_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
      redir_vld |=> (!redir_vld || irq_pulse)); // R8
endmodule

bind irq_entry_unit irq_entry_unit_chk #(
   .PC_W(PC_W), .SW_W(SW_W), .IE_POS(IE_POS), .SM_POS(SM_POS),
   .MSB_FIRST(MSB_FIRST), .VECTOR(VECTOR)
) chk_i (.*);

// File: tb/irq_entry_unit_tb_top.sv
module irq_entry_unit_tb_top;
   localparam int PC_W = 32;
   localparam int SW_W = 32;
   localparam logic [31:0] VEC = 32'hFFFF_F138;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic irq_pulse = 1'b0, dbg_trap = 1'b0;
   logic [PC_W-1:0] pc_now = '0;
   logic [SW_W-1:0] stat_now = '0;
   logic redir_vld, bkpc_we, bkstat_we, stat_we, sp_swap, sp_sel;
   logic [PC_W-1:0] redir_pc, bkpc_d;
   logic [SW_W-1:0] bkstat_d, stat_d;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct {
      bit          take;
      bit          swap;
      logic [31:0] pc;
      logic [31:0] st;
      string       tag;
   } exp_t;
   exp_t sb[$];

   always #4 clk = ~clk; // 125 MHz

   irq_entry_unit dut_i (
      .clk(clk), .rst_n(rst_n), .irq_pulse(irq_pulse), .dbg_trap(dbg_trap),
      .pc_now(pc_now), .stat_now(stat_now),
      .redir_vld(redir_vld), .redir_pc(redir_pc),
      .bkpc_we(bkpc_we), .bkpc_d(bkpc_d),
      .bkstat_we(bkstat_we), .bkstat_d(bkstat_d),
      .stat_we(stat_we), .stat_d(stat_d),
      .sp_swap(sp_swap), .sp_sel(sp_sel)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // Status word: stack-mode at bit 31, enable at bit 26, filler elsewhere.
   function automatic logic [31:0] mk_stat(bit ie, bit sm);
      return 32'h0123_4560 | (32'(sm) << 31) | (32'(ie) << 26);
   endfunction

   // Driver: applies one cycle of stimulus and queues the expected outcome.
   task automatic step(input bit irq, input bit ie, input bit sm, input bit dbg,
                       input logic [31:0] pc, input bit take, input string tag);
      exp_t e;
      @(negedge clk);
      irq_pulse = irq; dbg_trap = dbg; pc_now = pc; stat_now = mk_stat(ie, sm);
      e.take = take; e.swap = take && sm; e.pc = pc; e.st = mk_stat(ie, sm); e.tag = tag;
      sb.push_back(e);
   endtask

   // Monitor: samples 3 ns after the falling edge, before the rising edge.
   initial begin
      forever begin
         @(negedge clk);
         #3;
         if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            chk(redir_vld == e.take, e.tag, "redir_vld", 32'(redir_vld), 32'(e.take));
            chk(bkpc_we == e.take && bkstat_we == e.take && stat_we == e.take,
                e.tag, "load strobes (R10)", {29'd0, bkpc_we, bkstat_we, stat_we}, {29'd0, {3{e.take}}});
            chk(sp_swap == e.swap, e.tag, "sp_swap", 32'(sp_swap), 32'(e.swap));
            if (e.take) begin
               chk(redir_pc == VEC, e.tag, "redir_pc", redir_pc, VEC);
               chk(bkpc_d == e.pc, e.tag, "bkpc_d", bkpc_d, e.pc);
               chk(bkstat_d == e.st, e.tag, "bkstat_d", bkstat_d, e.st);
               chk(stat_d == '0, e.tag, "stat_d", stat_d, 32'd0);
               chk(sp_sel == 1'b0, e.tag, "sp_sel", 32'(sp_sel), 32'd0);
            end
         end
      end
   end

   initial begin
      for (int i = 0; i < 3; i++) @(negedge clk);
      stat_now = mk_stat(1, 0);
      #3;
      chk(redir_vld == 1'b0, "R1", "redir_vld in reset", 32'(redir_vld), 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      step(0, 1, 0, 0, 32'h0000_0010, 0, "R1");
      step(1, 1, 1, 0, 32'h0000_0100, 1, "R2 R3 R4 R5");
      step(0, 1, 0, 0, 32'h0000_0108, 0, "R8");
      step(1, 1, 0, 0, 32'h0000_0200, 1, "R5 sm0");
      step(1, 0, 1, 0, 32'h0000_0300, 0, "R6 masked");
      step(0, 0, 1, 0, 32'h0000_0308, 0, "R6 still masked");
      step(0, 1, 1, 0, 32'h0000_0400, 1, "R6 retry");
      step(0, 1, 0, 0, 32'h0000_0408, 0, "R8 cleared");
      step(1, 0, 0, 0, 32'h0000_0500, 0, "R7 first");
      step(1, 0, 0, 0, 32'h0000_0508, 0, "R7 second");
      step(0, 1, 0, 0, 32'h0000_0510, 1, "R7 one take");
      step(0, 1, 0, 0, 32'h0000_0518, 0, "R7 dropped");
      step(1, 1, 1, 1, 32'h0000_0600, 0, "R9 trap wins");
      step(0, 1, 1, 0, 32'h0000_0608, 1, "R9 later");
      step(0, 1, 0, 0, 32'h0000_0610, 0, "R9 quiet");
      step(1, 0, 0, 0, 32'h0000_0700, 0, "R8 pend");
      step(1, 1, 0, 0, 32'h0000_0708, 1, "R8 merge");
      step(0, 1, 0, 0, 32'h0000_0710, 0, "R8 merged");
      step(0, 0, 1, 1, 32'h0000_0718, 0, "R10 idle");
      step(0, 0, 0, 0, 32'h0, 0, "R10 idle");
      @(negedge clk); irq_pulse = 0;
      @(negedge clk);
      done = 1'b1;
   end

   initial begin
      for (int c = 0; c < 2000; c++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      end
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule